// File: doc/BRIEF.md
# Oversampling Serial Byte Receiver

This block recovers 8-bit bytes from an asynchronous serial line. Everything runs on one system clock. A built-in divider produces a one-clock enable pulse, called a tick, at sixteen times the bit rate, and all bit timing is counted in ticks. The line first passes through a flip-flop synchronizer, and a start is detected as a high-to-low step of the synchronized level. From that step the receiver counts ticks to reach the centre of the start bit and of each later bit. At each centre it takes a two-out-of-three vote of neighbouring tick samples.

A start bit that votes high at its centre is treated as noise, and the receiver goes back to idle. Data bits enter a shift register at its top end, so the first bit received ends up in bit 0. When the stop bit has been voted, the byte is presented with a one-clock valid pulse. If the stop bit voted low, the byte is still delivered, and an error flag is raised together with it. A system integrator sets the divider parameter to the clock frequency divided by sixteen times the bit rate. For example, a 50 MHz clock at 9600 bit/s needs a divider of about 326.

Top module: `uart_os_rx`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, rx_valid_o and frame_err_o are 0 and rx_data_o is 0, and the receiver is idle.
- R2: A frame is a 0 start bit, then 8 data bits with the least significant bit first, then a 1 stop bit. The byte received is presented on rx_data_o.
- R3: Only a 1-to-0 step of the line, after a two-flop synchronizer, starts a frame, and only while the receiver is idle. Level changes inside a frame never restart it.
- R4: If the start bit votes 1 at its centre, the frame is dropped without a valid pulse, and the receiver waits for a new 1-to-0 step.
- R5: Each bit value is the majority of three tick samples. Counting ticks from start detection, these are taken at counts 7, 8 and 9 of each 16-tick bit period. A disturbance lasting one tick therefore does not change a received bit.
- R6: rx_valid_o is high for exactly one clock per accepted frame. It rises in the clock after the tick on which the stop bit is voted. A tick occurs every CLK_DIV clocks.
- R7: A stop bit that votes 0 still delivers the byte, with frame_err_o at 1 in the same cycle as rx_valid_o. Otherwise frame_err_o is 0. rx_data_o and frame_err_o hold their values until the next valid pulse.
- R8: The receiver is idle again right after the stop-bit vote. Back-to-back frames with a single stop bit, or with a shortened stop bit, are all received.
- R9: Pulling rst_n low in the middle of a frame aborts that frame. No valid pulse follows for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rx_i | input | 1 | Asynchronous serial input, idle high |
| rx_data_o | output | DATA_BITS | Last received byte |
| rx_valid_o | output | 1 | One-clock pulse when a byte is delivered |
| frame_err_o | output | 1 | Stop bit of the delivered byte voted 0 |

## Verification
Two functions can fall in the same cycle. The first is delivering a byte with its error flag. The second is going back to idle, ready for the next start step, so that a start edge arriving at once after the stop vote is caught. The bench provokes this with back-to-back frames and with a stop bit cut to about thirteen ticks, so the next start edge falls just after the stop vote. A behavioural per-clock model judges every cycle, and a byte scoreboard checks that each frame appears exactly once with the right error flag. Frames with a low stop bit, single-tick glitches at the vote points, false starts and a reset in mid-frame cover the remaining corners.

// File: rtl/uart_os_rx_pkg.sv
package uart_os_rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/uart_tick_div.sv
module uart_tick_div #(
  parameter int CLK_DIV = 326
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_n;

  assign tick_o = (cnt_q == LAST);

  always_comb begin
    cnt_n = cnt_q + 1'b1;
    if (tick_o) cnt_n = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  generate
    if (CLK_DIV > 1) begin : g_gap
      AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o); // R6
    end
  endgenerate
endmodule

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_i,
  output logic rx_s_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q, chain_n;
  logic              dly_q;

  always_comb begin
    chain_n = {chain_q[STAGES-2:0], rx_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      dly_q   <= 1'b1;
    end else begin
      chain_q <= chain_n;
      dly_q   <= chain_q[STAGES-1];
    end
  end

  assign rx_s_o = chain_q[STAGES-1];
  assign fall_o = dly_q & ~chain_q[STAGES-1];

  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o); // R3
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_os_rx_pkg::*;
#(
  parameter int DATA_BITS  = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_i,
  input  logic                 rx_s_i,
  input  logic                 fall_i,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 valid_o,
  output logic                 err_o
);
  localparam int CW = $clog2(OVERSAMPLE);
  localparam int NW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [CW-1:0] SAMP_A = CW'(OVERSAMPLE / 2 - 1);
  localparam logic [CW-1:0] SAMP_B = CW'(OVERSAMPLE / 2);
  localparam logic [CW-1:0] SAMP_C = CW'(OVERSAMPLE / 2 + 1);
  localparam logic [NW-1:0] LAST_BIT = NW'(DATA_BITS - 1);

  rx_state_e            state_q, state_n;
  logic [CW-1:0]        bcnt_q, bcnt_n;
  logic [NW-1:0]        nbit_q, nbit_n;
  logic                 sa_q, sa_n, sb_q, sb_n;
  logic [DATA_BITS-1:0] shreg_q, shreg_n;
  logic [DATA_BITS-1:0] data_q, data_n;
  logic                 valid_q, valid_n, err_q, err_n;
  logic                 maj;
  logic                 vote_now;

  assign maj      = (sa_q & sb_q) | (sa_q & rx_s_i) | (sb_q & rx_s_i);
  assign vote_now = tick_i && (bcnt_q == SAMP_C);

  always_comb begin
    state_n = state_q;
    bcnt_n  = bcnt_q;
    nbit_n  = nbit_q;
    sa_n    = sa_q;
    sb_n    = sb_q;
    shreg_n = shreg_q;
    data_n  = data_q;
    err_n   = err_q;
    valid_n = 1'b0;
    if (state_q == RX_IDLE) begin
      if (fall_i) begin
        state_n = RX_START;
        bcnt_n  = '0;
      end
    end else if (tick_i) begin
      bcnt_n = bcnt_q + 1'b1;
      if (bcnt_q == SAMP_A) sa_n = rx_s_i;
      if (bcnt_q == SAMP_B) sb_n = rx_s_i;
      if (vote_now) begin
        unique case (state_q)
          RX_START: begin
            if (maj) state_n = RX_IDLE;
            else begin
              state_n = RX_DATA;
              nbit_n  = '0;
            end
          end
          RX_DATA: begin
            shreg_n = {maj, shreg_q[DATA_BITS-1:1]};
            if (nbit_q == LAST_BIT) state_n = RX_STOP;
            else                    nbit_n  = nbit_q + 1'b1;
          end
          RX_STOP: begin
            data_n  = shreg_q;
            err_n   = ~maj;
            valid_n = 1'b1;
            state_n = RX_IDLE;
          end
          default: state_n = RX_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      bcnt_q  <= '0;
      nbit_q  <= '0;
      sa_q    <= 1'b0;
      sb_q    <= 1'b0;
      shreg_q <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      bcnt_q  <= bcnt_n;
      nbit_q  <= nbit_n;
      sa_q    <= sa_n;
      sb_q    <= sb_n;
      shreg_q <= shreg_n;
      data_q  <= data_n;
      valid_q <= valid_n;
      err_q   <= err_n;
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;
  assign err_o   = err_q;

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q); // R6
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> ($stable(data_q) && $stable(err_q))); // R7
  AST_FALSE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_START && vote_now && maj) |=> (state_q == RX_IDLE)); // R4
  AST_IDLE_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_IDLE && !fall_i) |=> (state_q == RX_IDLE)); // R3
  AST_READY_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> (state_q == RX_IDLE)); // R8
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx #(
  parameter int CLK_DIV     = 326,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_BITS   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_i,
  output logic [DATA_BITS-1:0] rx_data_o,
  output logic                 rx_valid_o,
  output logic                 frame_err_o
);
  localparam int OVERSAMPLE = 16;

  logic tick;
  logic rx_s;
  logic fall;

  uart_tick_div #(.CLK_DIV(CLK_DIV)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick)
  );

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rx_i   (rx_i),
    .rx_s_o (rx_s),
    .fall_o (fall)
  );

  uart_rx_frame #(.DATA_BITS(DATA_BITS), .OVERSAMPLE(OVERSAMPLE)) u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick),
    .rx_s_i  (rx_s),
    .fall_i  (fall),
    .data_o  (rx_data_o),
    .valid_o (rx_valid_o),
    .err_o   (frame_err_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !rx_valid_o); // R1
endmodule

// File: tb/tb_uart_os_rx.sv
`timescale 1ns/1ps
module tb_uart_os_rx;
  localparam int DIV = 4;
  localparam int BITCLK = 16 * DIV;

  logic clk, rst_n, rx;
  logic [7:0] rx_data;
  logic rx_valid, frame_err;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [8:0] sb_q[$];

  uart_os_rx #(.CLK_DIV(DIV), .SYNC_STAGES(2), .DATA_BITS(8)) dut (
    .clk(clk), .rst_n(rst_n), .rx_i(rx),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .frame_err_o(frame_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic ok, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model, advanced on every clock
  int   m_tc, m_st, m_b, m_n;
  logic m_s1, m_s2, m_d, m_a, m_m, m_valid, m_err;
  logic [7:0] m_sh, m_data;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tc = 0; m_st = 0; m_b = 0; m_n = 0;
      m_s1 = 1; m_s2 = 1; m_d = 1; m_a = 0; m_m = 0;
      m_valid = 0; m_err = 0; m_sh = 0; m_data = 0;
    end else begin
      automatic logic fall = m_d && !m_s2;
      automatic logic tick = (m_tc == DIV - 1);
      automatic logic s = m_s2;
      automatic int votes;
      m_valid = 0;
      if (m_st == 0) begin
        if (fall) begin m_st = 1; m_b = 0; end
      end else if (tick) begin
        if (m_b == 9) begin
          votes = int'(m_a) + int'(m_m) + int'(s);
          if (m_st == 1) begin
            if (votes >= 2) m_st = 0; else begin m_st = 2; m_n = 0; end
          end else if (m_st == 2) begin
            m_sh = {(votes >= 2), m_sh[7:1]};
            if (m_n == 7) m_st = 3; else m_n++;
          end else begin
            m_data = m_sh; m_err = (votes < 2); m_valid = 1; m_st = 0;
          end
        end
        if (m_b == 7) m_a = s;
        if (m_b == 8) m_m = s;
        m_b = (m_b + 1) % 16;
      end
      m_tc = tick ? 0 : m_tc + 1;
      m_d = m_s2; m_s2 = m_s1; m_s1 = rx;
    end
  end

  // per-clock comparison and byte scoreboard, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk("R6 valid vs model", rx_valid === m_valid, rx_valid, m_valid);
      chk("R2 data vs model", rx_data === m_data, rx_data, m_data);
      chk("R7 err vs model", frame_err === m_err, frame_err, m_err);
      if (rx_valid === 1'b1) begin
        if (sb_q.size() == 0)
          chk("R4 R9 unexpected strobe", 1'b0, 1, 0);
        else begin
          automatic logic [8:0] e = sb_q.pop_front();
          chk("R2 scoreboard byte", rx_data === e[7:0], rx_data, e[7:0]);
          chk("R7 scoreboard err", frame_err === e[8], frame_err, e[8]);
        end
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); rx = 1'b1; end
  endtask

  task automatic send(input logic [7:0] b, input logic stopv, input int stop_len,
                      input int gbit, input logic expect_byte);
    if (expect_byte) sb_q.push_back({~stopv, b});
    for (int j = 0; j < 10; j++) begin
      automatic int len = (j == 9) ? stop_len : BITCLK;
      for (int c = 0; c < len; c++) begin
        automatic logic v = (j == 0) ? 1'b0 : (j == 9) ? stopv : b[j-1];
        if (j == gbit && c >= 8 * DIV + 2 && c < 9 * DIV + 2) v = ~v;
        @(negedge clk);
        rx = v;
      end
    end
  endtask

  initial begin
    rx = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", rx_valid === 1'b0, rx_valid, 0);
    chk("R1 reset err", frame_err === 1'b0, frame_err, 0);
    chk("R1 reset data", rx_data === 8'h00, rx_data, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", rx_valid === 1'b0 && rx_data === 8'h00, rx_data, 0);
    idle(2 * BITCLK);
    // R2 plain bytes
    send(8'h55, 1'b1, BITCLK, -1, 1'b1); idle(BITCLK);
    send(8'hA5, 1'b1, BITCLK, -1, 1'b1); idle(BITCLK);
    send(8'h00, 1'b1, BITCLK, -1, 1'b1); idle(BITCLK);
    send(8'hFF, 1'b1, BITCLK, -1, 1'b1); idle(BITCLK);
    // R7 low stop bit still delivers, flag clears afterwards
    send(8'h3C, 1'b0, BITCLK, -1, 1'b1); idle(BITCLK);
    send(8'h00, 1'b0, BITCLK, -1, 1'b1); idle(BITCLK);
    send(8'h81, 1'b1, BITCLK, -1, 1'b1); idle(BITCLK);
    chk("R7 flag cleared", frame_err === 1'b0, frame_err, 0);
    // R4 false start: short low pulse
    for (int i = 0; i < 3 * DIV; i++) begin @(negedge clk); rx = 1'b0; end
    idle(2 * BITCLK);
    chk("R4 no byte from false start", sb_q.size() == 0 && rx_data === 8'h81,
        rx_data, 8'h81);
    send(8'h6E, 1'b1, BITCLK, -1, 1'b1); idle(BITCLK);
    // R5 single-tick glitches at vote points
    send(8'h96, 1'b1, BITCLK, 0, 1'b1); idle(BITCLK);
    send(8'h96, 1'b1, BITCLK, 5, 1'b1); idle(BITCLK);
    send(8'h4B, 1'b1, BITCLK, 9, 1'b1); idle(BITCLK);
    chk("R5 glitched stop no err", frame_err === 1'b0, frame_err, 0);
    // R8 back-to-back and shortened stop
    send(8'h12, 1'b1, BITCLK, -1, 1'b1);
    send(8'h34, 1'b1, BITCLK, -1, 1'b1);
    send(8'h56, 1'b1, BITCLK, -1, 1'b1);
    send(8'h78, 1'b1, 13 * DIV, -1, 1'b1);
    send(8'hC3, 1'b1, 13 * DIV, -1, 1'b1);
    send(8'h0F, 1'b1, BITCLK, -1, 1'b1); idle(2 * BITCLK);
    chk("R8 all back-to-back received", sb_q.size() == 0, sb_q.size(), 0);
    // R9 reset in mid-frame
    for (int i = 0; i < 3 * BITCLK; i++) begin @(negedge clk); rx = (i >= BITCLK) ? i[6] : 1'b0; end
    @(negedge clk); rx = 1'b1; rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9 reset clears valid", rx_valid === 1'b0 && rx_data === 8'h00, rx_data, 0);
    rst_n = 1'b1;
    idle(2 * BITCLK);
    chk("R9 no byte after abort", sb_q.size() == 0 && rx_data === 8'h00, rx_data, 0);
    send(8'hE7, 1'b1, BITCLK, -1, 1'b1); idle(2 * BITCLK);
    chk("R2 R8 final queue empty", sb_q.size() == 0, sb_q.size(), 0);
    chk("R2 final byte", rx_data === 8'hE7, rx_data, 8'hE7);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule